// File: doc/BRIEF.md
# Serial Transmitter with Line Break

This block serialises bytes onto an asynchronous transmit line and can also hold that line low as a break condition. A byte is written into a one-entry holding register. It moves to a shift register as soon as the shifter is free and is then sent as a frame. The frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit and a high stop bit. Every bit lasts sixteen pulses of an externally supplied baud tick.

A break is handled like a character. A start-break strobe takes the holding slot, and the break begins once any frame in flight has finished. The line then stays low for at least one full frame time, counted with the parity setting in force when the break begins. It is released only after a stop-break strobe. After a break, the line stays high for one further bit time before anything else is sent. The ready flag gates every command, so software drives the block with the same handshake it uses for data.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1 and `tx_empty` is 1.
- R2: A frame is a start bit (0), then data bits 0 to 7 with the least significant bit first, then the optional parity bit, then a stop bit (1). Each bit lasts `OVERSAMPLE` (16) baud ticks.
- R3: `parity_mode` 2'b01 selects even parity, so the data bits and the parity bit together hold an even number of ones. 2'b10 selects odd parity. 2'b00 and 2'b11 leave the parity slot out of the frame.
- R4: A write is taken only while `tx_ready` is 1. `tx_ready` drops on the cycle after the write and returns to 1 one cycle later, when the byte moves into the shifter. `tx_empty` is 1 only when no byte is held, no break is pending and the shifter is idle.
- R5: The bit time scales with the baud tick. With one tick every three clocks, a bit lasts 48 clocks.
- R6: A break keeps `txd` low for at least one full frame time: 10 bit times without parity, 11 with parity. If stop-break arrives early, the low time is exactly one frame time.
- R7: A start-break accepted while a frame is being shifted out waits for that frame to finish, stop bit included, before `txd` goes low.
- R8: While a break is pending or active, a further start-break has no effect.
- R9: A stop-break with no accepted start-break before it is ignored. It is not remembered for a later break.
- R10: While a break is pending but not yet started, `tx_ready` is 0, and a byte written in that window is discarded and never sent.
- R11: When start-break and stop-break are asserted in the same cycle, start-break is taken and stop-break is dropped.
- R12: Without a stop-break, the break lasts indefinitely. After the break ends, `txd` stays high for at least one bit time before the next start bit.
- R13: Accepting start-break clears `tx_ready` and `tx_empty`. Once the break is on the line, `tx_ready` is 1 again so that stop-break can be given, and `tx_empty` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| parity_mode | input | 2 | 00 or 11 no parity, 01 even, 10 odd |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| brk_start | input | 1 | Start-break strobe |
| brk_stop | input | 1 | Stop-break strobe |
| txd | output | 1 | Serial line, high when idle |
| tx_ready | output | 1 | The holding slot accepts a byte or a command |
| tx_empty | output | 1 | Nothing is held, pending or being shifted |

## Verification
Frames are decoded bit by bit for several byte patterns. The pattern 0xA5 separates LSB-first from MSB-first order. The byte 0x03 sent under even and odd parity shows whether the parity sense is inverted, and a frame with no parity shows whether the parity slot is really removed. The all-zero byte gives a measurable low run that fixes the bit length at both tick rates. Breaks are tried from idle, queued behind a frame in flight, stopped early and stopped late, with repeated, stray and simultaneous commands. These cases separate a minimum-length break from one that is cut short, a queued break from one that corrupts the frame, and an ignored command from a remembered one.

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic [1:0]           parity_mode,
  input  logic                 wr_en,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic                 brk_start,
  input  logic                 brk_stop,
  output logic                 txd,
  output logic                 tx_ready,
  output logic                 tx_empty
);
  localparam int FW = DATA_BITS + 3;
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int NW = $clog2(FW + 1);

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_BRK, S_HOLD, S_GUARD} st_t;

  st_t                  st;
  logic                 hold_vld, brk_pend, stop_req;
  logic [DATA_BITS-1:0] hold_dat;
  logic [FW-1:0]        shreg;
  logic [CW-1:0]        tcnt;
  logic [NW-1:0]        nleft;

  wire par_on  = (parity_mode == 2'b01) || (parity_mode == 2'b10);
  wire par_bit = (^hold_dat) ^ (parity_mode == 2'b10);
  wire [FW-1:0] frame = par_on ? {1'b1, par_bit, hold_dat, 1'b0}
                               : {2'b11, hold_dat, 1'b0};
  wire [NW-1:0] flen = par_on ? NW'(FW) : NW'(FW - 1);

  wire brk_on   = (st == S_BRK) || (st == S_HOLD);
  assign tx_ready = !hold_vld && !brk_pend;
  assign tx_empty = tx_ready && (st == S_IDLE);
  assign txd      = (st == S_DATA) ? shreg[0] : !brk_on;

  wire start_ok = brk_start && tx_ready && !brk_on;
  wire stop_ok  = brk_stop && !brk_start && tx_ready && brk_on && !stop_req;
  wire wr_ok    = wr_en && tx_ready && !start_ok;
  wire bit_end  = baud_tick && (tcnt == CW'(OVERSAMPLE - 1));
  wire last_bit = (nleft == NW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      hold_vld <= 1'b0;
      hold_dat <= '0;
      brk_pend <= 1'b0;
      stop_req <= 1'b0;
      shreg    <= '1;
      tcnt     <= '0;
      nleft    <= '0;
    end else begin
      if (wr_ok) begin
        hold_vld <= 1'b1;
        hold_dat <= wr_data;
      end
      if (start_ok) brk_pend <= 1'b1;
      if (stop_ok)  stop_req <= 1'b1;
      if (baud_tick) tcnt <= bit_end ? '0 : tcnt + 1'b1;

      case (st)
        S_IDLE: begin
          tcnt <= '0;
          if (brk_pend) begin
            st       <= S_BRK;
            brk_pend <= 1'b0;
            nleft    <= flen;
            shreg    <= '0;
          end else if (hold_vld) begin
            st       <= S_DATA;
            hold_vld <= 1'b0;
            nleft    <= flen;
            shreg    <= frame;
          end
        end
        S_DATA: if (bit_end) begin
          shreg <= {1'b1, shreg[FW-1:1]};
          nleft <= nleft - 1'b1;
          if (last_bit) st <= S_IDLE;
        end
        S_BRK: if (bit_end) begin
          nleft <= nleft - 1'b1;
          if (last_bit) begin
            if (stop_req) begin
              st       <= S_GUARD;
              stop_req <= 1'b0;
            end else begin
              st <= S_HOLD;
            end
          end
        end
        S_HOLD: begin
          tcnt <= '0;
          if (stop_req) begin
            st       <= S_GUARD;
            stop_req <= 1'b0;
          end
        end
        S_GUARD: if (bit_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk #(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic       wr_en,
  input logic       brk_start,
  input logic       txd,
  input logic       tx_ready,
  input logic       tx_empty,
  input logic [2:0] st,
  input logic       stop_req
);
  localparam logic [2:0] C_BRK = 3'd2, C_HOLD = 3'd3, C_GUARD = 3'd4;
  localparam int MIN_TICKS = (DATA_BITS + 2) * OVERSAMPLE;

  logic [15:0] low_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_ticks <= '0;
    else if (txd) low_ticks <= '0;
    else if (baud_tick && low_ticks != 16'hFFFF) low_ticks <= low_ticks + 1'b1;
  end

  wire in_brk = (st == C_BRK) || (st == C_HOLD);

  a_r1_empty_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && tx_ready));

  a_r4_write_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_ready && !brk_start) |=> !tx_ready);

  a_r6_min_break: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_GUARD && ($past(st) == C_BRK || $past(st) == C_HOLD)) |-> low_ticks >= 16'(MIN_TICKS));

  a_r9_no_stale_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_brk |-> !stop_req);

  a_r13_break_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_start && tx_ready && !in_brk) |=> (!tx_ready && !tx_empty));
endmodule

bind uart_tx_brk uart_tx_brk_chk #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
  .brk_start(brk_start), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty),
  .st(st), .stop_req(stop_req)
);

// File: tb/tb_uart_tx_brk.sv
`timescale 1ns/1ps
module tb_uart_tx_brk;
  logic clk = 0, rst_n = 0, baud_tick = 0;
  logic [1:0] parity_mode = 2'b00;
  logic wr_en = 0, brk_start = 0, brk_stop = 0;
  logic [7:0] wr_data = 0;
  logic txd, tx_ready, tx_empty;
  int tests = 0, fails = 0, tdiv = 1, tphase = 0;

  uart_tx_brk dut (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .parity_mode(parity_mode),
    .wr_en(wr_en), .wr_data(wr_data), .brk_start(brk_start), .brk_stop(brk_stop),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tphase = (tphase + 1 >= tdiv) ? 0 : tphase + 1;
    baud_tick = (tphase == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lo);
    tests++;
    if (act < lo) begin
      fails++;
      $display("FAIL %s: actual %0d expected at least %0d", req, act, lo);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    while (!tx_ready) @(negedge clk);
    wr_data = d; wr_en = 1;
    @(negedge clk) wr_en = 0;
  endtask

  task automatic pulse_start();
    brk_start = 1; @(negedge clk) brk_start = 0;
  endtask

  task automatic pulse_stop();
    brk_stop = 1; @(negedge clk) brk_stop = 0;
  endtask

  task automatic recv(input bit par_en, output logic [7:0] d, output logic p, output logic s);
    do @(negedge clk); while (txd !== 1'b0);
    repeat (8 * tdiv) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (16 * tdiv) @(negedge clk);
      d[i] = txd;
    end
    p = 1'b1;
    if (par_en) begin
      repeat (16 * tdiv) @(negedge clk);
      p = txd;
    end
    repeat (16 * tdiv) @(negedge clk);
    s = txd;
  endtask

  task automatic low_run(output int n);
    do @(negedge clk); while (txd !== 1'b0);
    n = 0;
    while (txd === 1'b0) begin n++; @(negedge clk); end
  endtask

  task automatic high_run(output int n);
    n = 0;
    while (txd === 1'b1) begin n++; @(negedge clk); end
  endtask

  task automatic quiet(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  task automatic settle();
    while (!tx_empty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 txd", txd, 1); chk("R1 ready", tx_ready, 1); chk("R1 empty", tx_empty, 1);
  endtask

  task automatic t_frame(input logic [7:0] d, input logic [1:0] pm, input string tag);
    logic [7:0] got; logic p, s, exp_p; bit pe;
    parity_mode = pm;
    pe = (pm == 2'b01) || (pm == 2'b10);
    exp_p = pe ? ((^d) ^ (pm == 2'b10)) : 1'b1;
    fork
      recv(pe, got, p, s);
      begin
        write_byte(d);
        chk({tag, " R4 ready low after write"}, tx_ready, 0);
        @(negedge clk);
        chk({tag, " R4 ready after handoff"}, tx_ready, 1);
        chk({tag, " R4 empty while shifting"}, tx_empty, 0);
      end
    join
    chk({tag, " R2 data"}, got, d);
    chk({tag, " R3 parity"}, p, exp_p);
    chk({tag, " R2 stop"}, s, 1);
    settle();
  endtask

  task automatic t_back_to_back();
    logic [7:0] a, b; logic p, s1, s2;
    parity_mode = 2'b00;
    fork
      begin recv(0, a, p, s1); recv(0, b, p, s2); end
      begin write_byte(8'h3C); write_byte(8'hC3); end
    join
    chk("R4 first queued byte", a, 8'h3C);
    chk("R4 second queued byte", b, 8'hC3);
    settle();
  endtask

  task automatic t_bit_len(input int div, input string req);
    int n;
    tdiv = div; parity_mode = 2'b00;
    repeat (4) @(negedge clk);
    fork low_run(n); write_byte(8'h00); join
    tests++;
    if (n < 144 * div - div || n > 144 * div + div) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, n, 144 * div);
    end
    settle();
    tdiv = 1;
  endtask

  task automatic t_break_early(input logic [1:0] pm, input int exp_len);
    int n, h;
    parity_mode = pm;
    fork
      low_run(n);
      begin
        pulse_start();
        chk("R13 ready cleared", tx_ready, 0);
        chk("R13 empty cleared", tx_empty, 0);
        @(negedge clk);
        chk("R13 ready during break", tx_ready, 1);
        chk("R13 empty during break", tx_empty, 0);
        repeat (20) @(negedge clk);
        pulse_stop();
      end
    join
    chk("R6 early stop low time", n, exp_len);
    h = 0;
    while (!tx_empty) begin h++; @(negedge clk); end
    chk_ge("R12 guard bit", h, 15);
    settle();
  endtask

  task automatic t_break_late();
    int n, h;
    parity_mode = 2'b00;
    fork
      begin low_run(n); high_run(h); end
      begin
        pulse_start();
        repeat (300) @(negedge clk);
        chk("R12 still low without stop", txd, 0);
        pulse_stop();
        write_byte(8'h55);
      end
    join
    chk_ge("R12 late stop low time", n, 300);
    chk_ge("R12 high gap before next start", h, 16);
    settle();
  endtask

  task automatic t_second_start();
    int n, lows;
    parity_mode = 2'b00;
    fork
      low_run(n);
      begin
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_stop();
      end
    join
    chk("R8 break length", n, 160);
    quiet(500, lows);
    chk("R8 no second break", lows, 0);
    settle();
  endtask

  task automatic t_stray_stop();
    int n;
    parity_mode = 2'b00;
    pulse_stop();
    repeat (5) @(negedge clk);
    chk("R9 stray stop no effect", txd, 1);
    fork
      low_run(n);
      begin
        pulse_start();
        repeat (400) @(negedge clk);
        chk("R9 stop not remembered", txd, 0);
        pulse_stop();
      end
    join
    chk_ge("R9 break held", n, 400);
    settle();
  endtask

  task automatic t_both();
    int n;
    parity_mode = 2'b00;
    fork
      low_run(n);
      begin
        brk_start = 1; brk_stop = 1;
        @(negedge clk) begin brk_start = 0; brk_stop = 0; end
        repeat (300) @(negedge clk);
        chk("R11 start wins stop dropped", txd, 0);
        pulse_stop();
      end
    join
    chk_ge("R11 break length", n, 300);
    settle();
  endtask

  task automatic t_pending();
    logic [7:0] got; logic p, s; int n, lows;
    parity_mode = 2'b00;
    fork
      begin recv(0, got, p, s); low_run(n); end
      begin
        write_byte(8'h81);
        @(negedge clk);
        pulse_start();
        chk("R10 ready low while pending", tx_ready, 0);
        wr_data = 8'h18; wr_en = 1;
        @(negedge clk) wr_en = 0;
        repeat (250) @(negedge clk);
        pulse_stop();
      end
    join
    chk("R7 frame intact before break", got, 8'h81);
    chk("R7 stop bit before break", s, 1);
    chk("R7 break length", n, 160);
    quiet(500, lows);
    chk("R10 discarded byte not sent", lows, 0);
    chk("R10 empty afterwards", tx_empty, 1);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_frame(8'hA5, 2'b00, "A5 none");
    t_frame(8'h03, 2'b01, "03 even");
    t_frame(8'h03, 2'b10, "03 odd");
    t_frame(8'h07, 2'b01, "07 even");
    t_frame(8'h5A, 2'b11, "5A mode3");
    t_back_to_back();
    t_bit_len(1, "R2 bit length");
    t_bit_len(3, "R5 bit length slow tick");
    tdiv = 3;
    t_frame(8'h96, 2'b10, "R5 slow 96 odd");
    tdiv = 1;
    t_break_early(2'b00, 160);
    t_break_early(2'b01, 176);
    t_break_late();
    t_second_start();
    t_stray_stop();
    t_both();
    t_pending();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule